// File: doc/BRIEF.md
# Chopped Oversampling Conversion Sequencer

This block times each conversion of an oversampling ADC modulator. A free-running divider, clocked by the master oscillator, produces a one-cycle sample strobe at one of four rates. A conversion is a burst of elementary conversions. Each elementary conversion lasts a programmable power-of-two number of strobes. A chop output flips at every internal boundary of the burst, so that the offset of the input path cancels over the burst.

Software-style configuration arrives through a small write port with two word addresses. A conversion begins on a rising start request, on switching the continuous bit on, or on a defaults command. The defaults command also reloads every field and abandons any conversion in progress. While continuous operation is on, a new conversion follows the previous one with no gap. The PGA stage enables are only held and reported as a bypass mask. The modulator, the decimation arithmetic and the analog settings live elsewhere.

Top module: `convseq_top`

## Requirements
- R1: After reset, busy, chop, sample_stb, elem_done and conv_done are 0 and stage_bypass is 3'b111.
- R2: Timing word (address 0) bits [6:5] pick the strobe rate: 3 gives one sample_stb every 4 clocks, 2 every 8, 1 every 16 and 0 every 32. Within a conversion the first strobe comes that many clocks after the launch and the strobes stay evenly spaced. The rate in use is captured at launch.
- R3: Timing word bits [4:2] (k) set 8·2^k samples per elementary conversion. Bits [1:0] (n) set 2^n elementary conversions. busy is high for exactly divider × samples × elements clocks, starting one clock after the start request is sampled.
- R4: elem_done pulses for one clock after the last strobe of each elementary conversion. conv_done pulses for one clock, together with the final elem_done, once per completed conversion.
- R5: chop is 0 when a conversion launches. It toggles after each elementary conversion except the last, and it is 0 whenever the block is idle.
- R6: In single mode a start request acts on its rising edge only when the block is idle. A start received while busy is ignored, and holding start high does not launch a second conversion.
- R7: Writing timing bit [7] (continuous) from 0 to 1 launches a conversion one clock after the write. While the bit is 1, each finished conversion pulses conv_done and relaunches with busy staying high. Clearing the bit lets the current conversion finish and then stop.
- R8: A defaults command reloads the timing word to rate 3, k=2, n=1 and continuous 0, and sets the path word to modulator enabled with all stages off. It abandons any conversion in progress without a conv_done and launches a new conversion on the same clock edge.
- R9: Path word (address 1) bit [0] enables the modulator. When it is 0, start requests are ignored. Clearing it during a conversion ends busy at the next clock edge with no conv_done.
- R10: Writes to the timing word during a conversion do not change that conversion's length; they apply from the next launch.
- R11: Path word bits [3:1] enable PGA stages 1 to 3. stage_bypass is the inverse of those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Word select: 0 timing, 1 path |
| cfg_wdata | input | 8 | Configuration write data |
| start | input | 1 | Start request, acted on at its rising edge |
| dflt | input | 1 | Defaults command: reload fields and relaunch |
| busy | output | 1 | High while a conversion runs |
| sample_stb | output | 1 | One-clock modulator sample strobe |
| chop | output | 1 | Input chop polarity |
| elem_done | output | 1 | End of an elementary conversion |
| conv_done | output | 1 | End of a whole conversion |
| stage_bypass | output | 3 | Per-stage PGA bypass mask |

## Verification
A wrong sample or element count shows as a busy window that is too long or too short, a different number of elem_done pulses, or a misplaced final strobe. Each of these becomes visible within one conversion, at most a few thousand clocks. A wrong divider setting shifts the very first strobe after launch, so it shows within 32 clocks. A broken chop register leaves the polarity at 1 after busy falls, or gives the wrong number of toggles within the burst. Faults in the abort, relaunch and capture paths show in the clock that follows the defaults command, the modulator-off write or the end of a continuous conversion.

// File: rtl/convseq_pkg.sv
// Shared widths, field layouts and default values for the conversion sequencer.
package convseq_pkg;

    localparam int RATE_W       = 2;
    localparam int OSR_W        = 3;
    localparam int BURST_W      = 2;
    localparam int STAGES       = 3;
    localparam int DATA_W       = 8;
    localparam int ADDR_W       = 1;
    localparam int MIN_DIV_LOG  = 2;
    localparam int OSR_BASE_LOG = 3;

    localparam int DIV_CNT_W = MIN_DIV_LOG + (1 << RATE_W) - 1;
    localparam int SAMP_W    = OSR_BASE_LOG + (1 << OSR_W) - 1;
    localparam int ELEM_W    = (1 << BURST_W) - 1;

    // Timing word: continuous[7], rate[6:5], osr exponent[4:2], burst exponent[1:0]
    typedef struct packed {
        logic               cont;
        logic [RATE_W-1:0]  rate;
        logic [OSR_W-1:0]   osr;
        logic [BURST_W-1:0] burst;
    } timing_t;

    // Path word: stage enables[3:1], modulator enable[0]
    typedef struct packed {
        logic [STAGES-1:0] stage_en;
        logic              mod_en;
    } path_t;

    localparam timing_t TIMING_DEF = '{cont: 1'b0, rate: 2'b11, osr: 3'd2, burst: 2'd1};
    localparam path_t   PATH_DEF   = '{stage_en: '0, mod_en: 1'b1};

endpackage

// File: rtl/convseq_cfg.sv
// Configuration holder. Keeps the timing and path words, reloads defaults on
// command, and flags a continuous-bit 0->1 write as a registered launch request.
// Assumes the write port is single-cycle and the defaults command wins over writes.
module convseq_cfg
    import convseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dflt,
    output timing_t           timing,
    output path_t             path,
    output logic              kick
);

    localparam int TW = $bits(timing_t);
    localparam int PW = $bits(path_t);

    logic    hit_timing;
    logic    hit_path;
    timing_t new_timing;

    // Decode which word a write targets.
    always_comb begin
        hit_timing = wr && (addr == ADDR_W'(0));
        hit_path   = wr && (addr == ADDR_W'(1));
        new_timing = timing_t'(wdata[TW-1:0]);
    end

    // Hold both words and raise kick one clock after continuous is switched on.
    always_ff @(posedge clk) begin
        if (!rst_n || dflt) begin
            timing <= TIMING_DEF;
            path   <= PATH_DEF;
            kick   <= 1'b0;
        end else begin
            kick <= hit_timing && new_timing.cont && !timing.cont;
            if (hit_timing) begin
                timing <= new_timing;
            end
            if (hit_path) begin
                path <= path_t'(wdata[PW-1:0]);
            end
        end
    end

endmodule

// File: rtl/convseq_div.sv
// Sample strobe divider. A free-running counter is cleared at every launch;
// tick is high on the last count of a window of 2^(MIN_DIV_LOG + max_rate - rate)
// clocks. Assumes rate is steady between clears.
module convseq_div
    import convseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    localparam int MAX_RATE = (1 << RATE_W) - 1;

    logic [DIV_CNT_W-1:0] cnt;
    logic [DIV_CNT_W-1:0] mask;
    int                   span_log;

    // Build the low-bit mask that spans one strobe period.
    always_comb begin
        span_log = MIN_DIV_LOG + MAX_RATE - int'(rate);
        for (int b = 0; b < DIV_CNT_W; b++) begin
            mask[b] = (b < span_log);
        end
        tick = ((cnt & mask) == mask);
    end

    // Count oscillator clocks, restarting at each launch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/convseq_ctrl.sv
// Conversion sequencer. Launches a conversion on a start edge, a continuous
// kick, a defaults command or a continuous relaunch; counts samples within each
// elementary conversion and elementary conversions within the burst; drives the
// chop polarity and the done pulses. Assumes tick comes from a divider cleared
// by div_clear and driven with run_rate.
module convseq_ctrl
    import convseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dflt,
    input  logic              kick,
    input  timing_t           timing,
    input  logic              mod_en,
    input  logic              tick,
    output logic              busy,
    output logic              chop,
    output logic              elem_done,
    output logic              conv_done,
    output logic              div_clear,
    output logic [RATE_W-1:0] run_rate
);

    logic               start_q;
    logic [SAMP_W-1:0]  samp_cnt;
    logic [ELEM_W-1:0]  elem_cnt;
    logic [OSR_W-1:0]   run_osr;
    logic [BURST_W-1:0] run_burst;
    logic [SAMP_W-1:0]  samp_top;
    logic [ELEM_W-1:0]  elem_top;
    logic               samp_last;
    logic               elem_last;
    logic               user_go;
    logic               relaunch;
    logic               launch;
    timing_t            src;

    // Terminal counts of the running conversion.
    always_comb begin
        for (int b = 0; b < SAMP_W; b++) begin
            samp_top[b] = (b < OSR_BASE_LOG + int'(run_osr));
        end
        for (int b = 0; b < ELEM_W; b++) begin
            elem_top[b] = (b < int'(run_burst));
        end
        samp_last = (samp_cnt == samp_top);
        elem_last = (elem_cnt == elem_top);
    end

    // Decide whether this edge launches a conversion and from which fields.
    always_comb begin
        user_go   = !busy && mod_en && ((start && !start_q) || kick);
        relaunch  = busy && mod_en && tick && samp_last && elem_last && timing.cont;
        launch    = dflt || user_go || relaunch;
        div_clear = launch;
        src       = dflt ? TIMING_DEF : timing;
    end

    // Sequence state: launch, abort, count and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            busy      <= 1'b0;
            chop      <= 1'b0;
            elem_done <= 1'b0;
            conv_done <= 1'b0;
            samp_cnt  <= '0;
            elem_cnt  <= '0;
            run_osr   <= '0;
            run_burst <= '0;
            run_rate  <= '0;
        end else begin
            start_q   <= start;
            elem_done <= 1'b0;
            conv_done <= 1'b0;
            if (launch) begin
                busy      <= 1'b1;
                chop      <= 1'b0;
                samp_cnt  <= '0;
                elem_cnt  <= '0;
                run_osr   <= src.osr;
                run_burst <= src.burst;
                run_rate  <= src.rate;
                if (relaunch && !dflt) begin
                    elem_done <= 1'b1;
                    conv_done <= 1'b1;
                end
            end else if (busy && !mod_en) begin
                busy <= 1'b0;
                chop <= 1'b0;
            end else if (busy && tick) begin
                if (samp_last) begin
                    samp_cnt  <= '0;
                    elem_done <= 1'b1;
                    if (elem_last) begin
                        conv_done <= 1'b1;
                        busy      <= 1'b0;
                        chop      <= 1'b0;
                    end else begin
                        elem_cnt <= elem_cnt + 1'b1;
                        chop     <= !chop;
                    end
                end else begin
                    samp_cnt <= samp_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/convseq_top.sv
// Top of the chopped oversampling conversion sequencer. Joins the configuration
// holder, the strobe divider and the sequencer; gates the strobe with busy and
// reports disabled PGA stages as bypassed. Assumes one clock domain.
module convseq_top
    import convseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              dflt,
    output logic              busy,
    output logic              sample_stb,
    output logic              chop,
    output logic              elem_done,
    output logic              conv_done,
    output logic [STAGES-1:0] stage_bypass
);

    timing_t           timing_q;
    path_t             path_q;
    logic              kick;
    logic              tick;
    logic              div_clear;
    logic [RATE_W-1:0] run_rate;

    convseq_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .dflt   (dflt),
        .timing (timing_q),
        .path   (path_q),
        .kick   (kick)
    );

    convseq_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (div_clear),
        .rate  (run_rate),
        .tick  (tick)
    );

    convseq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dflt      (dflt),
        .kick      (kick),
        .timing    (timing_q),
        .mod_en    (path_q.mod_en),
        .tick      (tick),
        .busy      (busy),
        .chop      (chop),
        .elem_done (elem_done),
        .conv_done (conv_done),
        .div_clear (div_clear),
        .run_rate  (run_rate)
    );

    // Pass the strobe only while converting; report disabled stages as bypassed.
    always_comb begin
        sample_stb   = busy && tick;
        stage_bypass = ~path_q.stage_en;
    end

endmodule

// File: rtl/convseq_chk.sv
// Property checker for the conversion sequencer, attached by bind.
// Assumes a synchronous active-low reset held for at least one clock.
module convseq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic chop,
    input logic sample_stb,
    input logic elem_done,
    input logic conv_done,
    input logic dflt,
    input logic mod_en
);

    // R2: the fastest strobe period is 4 clocks, so strobes never abut
    p_stb_sparse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    // R4: a conversion end is always also an element end
    p_done_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> elem_done);

    // R5: chop rests at 0 when idle
    p_chop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !chop);

    // R5: a fresh conversion starts with chop at 0
    p_launch_chop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !chop);

    // R8: the defaults command leaves a running conversion with chop 0
    p_dflt_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dflt |=> (busy && !chop));

    // R9: with the modulator off the sequencer is idle next clock
    p_modoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en && !dflt) |=> !busy);

endmodule

bind convseq_top convseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .chop       (chop),
    .sample_stb (sample_stb),
    .elem_done  (elem_done),
    .conv_done  (conv_done),
    .dflt       (dflt),
    .mod_en     (path_q.mod_en)
);

// File: tb/convseq_top_test.sv
// Self-checking bench for convseq_top: a vector table of timing settings, then
// directed tests for reset, start handling, abort, continuous and defaults.
module convseq_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [0:0] cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       start = 1'b0;
    logic       dflt = 1'b0;
    logic       busy, sample_stb, chop, elem_done, conv_done;
    logic [2:0] stage_bypass;

    int total = 0;
    int fails = 0;

    always #10 clk = !clk;

    convseq_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .start        (start),
        .dflt         (dflt),
        .busy         (busy),
        .sample_stb   (sample_stb),
        .chop         (chop),
        .elem_done    (elem_done),
        .conv_done    (conv_done),
        .stage_bypass (stage_bypass)
    );

    // {rate[22:21], osr exponent[20:18], burst exponent[17:16], busy clocks[15:0]}
    localparam logic [22:0] VEC [7] = '{
        {2'd3, 3'd0, 2'd0, 16'd32},
        {2'd2, 3'd1, 2'd1, 16'd256},
        {2'd1, 3'd0, 2'd2, 16'd512},
        {2'd0, 3'd0, 2'd3, 16'd2048},
        {2'd3, 3'd3, 2'd0, 16'd256},
        {2'd3, 3'd7, 2'd0, 16'd4096},
        {2'd0, 3'd2, 2'd1, 16'd2048}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic kick_start();
        @(negedge clk);
        start = 1'b1;
    endtask

    // Observe one busy window; act: 1 start, 2 timing write, 3 path write,
    // 4 defaults, 5 keep start held; the action is driven when len reaches inj.
    task automatic run(input int act, input int inj, input logic [7:0] ad, input int d,
                       output int len, output int stb, output int ed, output int cd,
                       output int chg, output int gapbad, output int chop0);
        int   last;
        logic pc;
        len = 0; stb = 0; ed = 0; cd = 0; chg = 0; gapbad = 0; chop0 = 0;
        last = 0; pc = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (act != 5) start = 1'b0;
            dflt = 1'b0; cfg_wr = 1'b0;
            if (elem_done) ed++;
            if (conv_done) cd++;
            if (!busy) break;
            len++;
            if (len == 1) chop0 = int'(chop);
            else if (chop != pc) chg++;
            pc = chop;
            if (sample_stb) begin
                stb++;
                if (d > 0 && len - last != d) gapbad++;
                last = len;
            end
            if (len == inj) begin
                case (act)
                    1: start = 1'b1;
                    2: begin cfg_wr = 1'b1; cfg_addr = 1'b0; cfg_wdata = ad; end
                    3: begin cfg_wr = 1'b1; cfg_addr = 1'b1; cfg_wdata = ad; end
                    4: dflt = 1'b1;
                    default: ;
                endcase
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int len, stb, ed, cd, chg, gb, c0;
        int rate, osr, burst, d, nel, ns;
        bit quiet;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        quiet = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (busy || chop || sample_stb || elem_done || conv_done) quiet = 1'b0;
        end
        check(quiet, "R1 idle outputs", int'(quiet), 1);
        check(stage_bypass == 3'b111, "R1 bypass", int'(stage_bypass), 7);

        // Vector table: R2, R3, R4, R5
        for (int i = 0; i < 7; i++) begin
            rate  = int'(VEC[i][22:21]);
            osr   = int'(VEC[i][20:18]);
            burst = int'(VEC[i][17:16]);
            d     = 4 << (3 - rate);
            nel   = 1 << burst;
            ns    = (8 << osr) * nel;
            wr(1'b0, {1'b0, VEC[i][22:16]});
            kick_start();
            run(0, 0, 8'h00, d, len, stb, ed, cd, chg, gb, c0);
            check(len == int'(VEC[i][15:0]), "R3 busy length", len, int'(VEC[i][15:0]));
            check(stb == ns, "R3 strobe count", stb, ns);
            check(gb == 0, "R2 strobe spacing", gb, 0);
            check(ed == nel, "R4 elem_done count", ed, nel);
            check(cd == 1, "R4 conv_done count", cd, 1);
            check(chg == nel - 1, "R5 chop toggles", chg, nel - 1);
            check(c0 == 0 && chop == 1'b0, "R5 chop start/end", c0 + int'(chop), 0);
        end

        // R11: stage enables 101 give bypass 010
        wr(1'b1, 8'h0B);
        @(negedge clk);
        check(stage_bypass == 3'b010, "R11 bypass", int'(stage_bypass), 2);

        // R6: start while busy is ignored
        wr(1'b0, 8'h60);
        kick_start();
        run(1, 10, 8'h00, 4, len, stb, ed, cd, chg, gb, c0);
        check(len == 32, "R6 restart ignored", len, 32);

        // R6: holding start high launches only once
        @(negedge clk);
        start = 1'b1;
        run(5, 0, 8'h00, 4, len, stb, ed, cd, chg, gb, c0);
        check(len == 32, "R6 held start length", len, 32);
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy) quiet = 1'b0;
        end
        check(quiet, "R6 held start no relaunch", int'(quiet), 1);
        start = 1'b0;

        // R9: start ignored with modulator off
        wr(1'b1, 8'h00);
        kick_start();
        run(0, 0, 8'h00, 0, len, stb, ed, cd, chg, gb, c0);
        check(len == 0, "R9 start ignored", len, 0);
        check(stage_bypass == 3'b111, "R11 all bypassed", int'(stage_bypass), 7);

        // R9: clearing the modulator enable aborts
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h00);
        kick_start();
        run(3, 20, 8'h00, 32, len, stb, ed, cd, chg, gb, c0);
        check(len == 21, "R9 abort length", len, 21);
        check(cd == 0, "R9 abort no conv_done", cd, 0);
        wr(1'b1, 8'h01);

        // R10: timing write mid-conversion applies next time
        wr(1'b0, 8'h61);
        kick_start();
        run(2, 10, 8'h01, 4, len, stb, ed, cd, chg, gb, c0);
        check(len == 64, "R10 current length kept", len, 64);
        kick_start();
        run(0, 0, 8'h00, 32, len, stb, ed, cd, chg, gb, c0);
        check(len == 512, "R10 new rate used", len, 512);
        check(gb == 0, "R2 slowest spacing", gb, 0);

        // R7: continuous bit launches, relaunches, and stops after clearing
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'hE0;
        @(negedge clk);
        cfg_wr = 1'b0;
        run(2, 40, 8'h60, 4, len, stb, ed, cd, chg, gb, c0);
        check(len == 64, "R7 two back-to-back conversions", len, 64);
        check(cd == 2, "R7 conv_done per conversion", cd, 2);
        check(stb == 16, "R7 strobes", stb, 16);

        // R8: defaults abandon and relaunch
        wr(1'b1, 8'h0B);
        wr(1'b0, 8'h00);
        kick_start();
        run(4, 50, 8'h00, 0, len, stb, ed, cd, chg, gb, c0);
        check(len == 306, "R8 relaunch length", len, 306);
        check(ed == 2 && cd == 1, "R8 done pulses", ed * 10 + cd, 21);
        check(chg == 1, "R8 chop toggles", chg, 1);
        check(stage_bypass == 3'b111, "R8 stages off", int'(stage_bypass), 7);
        kick_start();
        run(0, 0, 8'h00, 4, len, stb, ed, cd, chg, gb, c0);
        check(len == 256, "R8 default timing kept", len, 256);
        check(stb == 64, "R8 default strobes", stb, 64);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule